// File: doc/BRIEF.md
# USB Charging Port Type Sequencer

This block decides what kind of USB port a device has been plugged into by stepping the analog front end through three detection stages in turn. First it checks for data contact. Then it runs a primary test that separates charging ports from standard downstream ports. A secondary test then separates dedicated chargers from charging downstream ports. A one-cycle start pulse launches the sequence. All waits are counted in pulses of a one-cycle millisecond tick input. Three comparator outputs from the analog front end are sampled at the end of each wait.

The sequencer drives six enables: the DM pull-down, the DP current source, the DP and DM voltage sources, and the DP and DM current sinks. At the end it reports a 3-bit port-type code together with a one-cycle done pulse. The code stays on the output until the next accepted start. Contact detection that finds no contact is not fatal. If primary detection then also misses, the port is reported as a floating charger. If contact was seen and primary detection misses, the primary test is repeated before the port is classed as a standard downstream port.

Top module: `chg_detect_seq`

## Requirements
- R1: After reset all six enables are low, done is low and the port-type code is 0 (unknown).
- R2: From the cycle after an accepted start, the contact stage drives only the DM pull-down and the DP current source, and both stay high until the contact stage ends.
- R3: The contact comparator is sampled on every 100th millisecond tick of the contact stage, for at most 6 samples. The stage ends at the first sample that sees contact, or after the sixth sample.
- R4: The primary stage drives only the DP voltage source and the DM current sink. The charging-port comparator is sampled on the 40th tick of each attempt.
- R5: A primary hit starts the secondary stage. This stage drives only the DM voltage source and the DP current sink and samples the dedicated-port comparator on its 40th tick. The result is 2 (DCP) if that comparator is high and 3 (CDP) if it is low.
- R6: If no contact sample saw contact and the first primary attempt misses, the result is 4 (floating), and the secondary stage is skipped.
- R7: If contact was seen and a primary attempt misses, the primary test is repeated up to 2 more times. A hit on any attempt leads to the secondary stage. If all 3 attempts miss, the result is 1 (SDP).
- R8: Done is high for exactly one cycle, at the same time as the final code first appears. All enables are low while idle and while done is high. The code holds until the next accepted start, which clears it to 0 in the following cycle.
- R9: A start pulse that arrives while a sequence is running, including the done cycle, is ignored.
- R10: At most one of the three enable groups (contact, primary, secondary) is active in any cycle, and the two enables of a group are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin detection |
| ms_tick_i | input | 1 | One-cycle pulse once per millisecond |
| contact_i | input | 1 | Data-contact comparator result |
| chgport_i | input | 1 | Charging-port comparator result |
| dedport_i | input | 1 | Dedicated-port comparator result |
| en_dm_pulldown_o | output | 1 | DM pull-down resistor enable |
| en_dp_isrc_o | output | 1 | DP current source enable |
| en_dp_vsrc_o | output | 1 | DP voltage source enable |
| en_dm_vsrc_o | output | 1 | DM voltage source enable |
| en_dp_isink_o | output | 1 | DP current sink enable |
| en_dm_isink_o | output | 1 | DM current sink enable |
| done_o | output | 1 | One-cycle completion pulse |
| port_type_o | output | 3 | Port type: 0 unknown, 1 SDP, 2 DCP, 3 CDP, 4 floating |

## Verification
The assertions check these on every cycle: the enable groups never overlap and the two enables of a group stay paired, done lasts one cycle with every enable low, a completed run never reports unknown, and the code only changes around a start or a done. They cannot tell whether the right code was chosen or whether a comparator was sampled on the right tick. The bench's scenarios show those behaviours. They cover contact seen early and late, contact timing out, primary retries that end in a late hit or in SDP, the DCP/CDP split, and a start pulse sent in the middle of a run.

// File: rtl/chg_detect_pkg.sv
package chg_detect_pkg;

    typedef enum logic [2:0] {
        PT_UNKNOWN  = 3'd0,
        PT_SDP      = 3'd1,
        PT_DCP      = 3'd2,
        PT_CDP      = 3'd3,
        PT_FLOATING = 3'd4
    } port_type_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_CONTACT   = 3'd1,
        ST_PRIMARY   = 3'd2,
        ST_SECONDARY = 3'd3,
        ST_FINISH    = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic dm_pulldown;
        logic dp_isrc;
        logic dp_vsrc;
        logic dm_isink;
        logic dm_vsrc;
        logic dp_isink;
    } analog_en_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic analog_en_t stage_enables(input seq_state_e st);
        analog_en_t e;
        e = '0;
        case (st)
            ST_CONTACT: begin
                e.dm_pulldown = 1'b1;
                e.dp_isrc     = 1'b1;
            end
            ST_PRIMARY: begin
                e.dp_vsrc  = 1'b1;
                e.dm_isink = 1'b1;
            end
            ST_SECONDARY: begin
                e.dm_vsrc  = 1'b1;
                e.dp_isink = 1'b1;
            end
            default: e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/chg_tick_timer.sv
module chg_tick_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_i,
    input  logic         tick_i,
    input  logic [W-1:0] limit_i,
    output logic         expire_o
);
    logic [W-1:0] cnt_q;

    assign expire_o = run_i && tick_i && (cnt_q == (limit_i - W'(1)));

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= expire_o ? '0 : cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/chg_enable_decode.sv
module chg_enable_decode
    import chg_detect_pkg::*;
(
    input  seq_state_e state_i,
    output analog_en_t en_o
);
    always_comb begin
        en_o = stage_enables(state_i);
    end
endmodule

// File: rtl/chg_seq_ctrl.sv
module chg_seq_ctrl
    import chg_detect_pkg::*;
#(
    parameter int CONTACT_POLL_MS = 100,
    parameter int CONTACT_POLLS   = 6,
    parameter int PRIMARY_MS      = 40,
    parameter int SECONDARY_MS    = 40,
    parameter int PRIMARY_RETRIES = 2,
    parameter int TW              = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          contact_i,
    input  logic          chgport_i,
    input  logic          dedport_i,
    input  logic          expire_i,
    output logic          run_o,
    output logic [TW-1:0] limit_o,
    output seq_state_e    state_o,
    output logic          done_o,
    output port_type_e    result_o
);
    localparam int PW = $clog2(CONTACT_POLLS + 1);
    localparam int RW = $clog2(PRIMARY_RETRIES + 1) < 1 ? 1 : $clog2(PRIMARY_RETRIES + 1);

    seq_state_e state_q;
    logic [PW-1:0] polls_q;
    logic [RW-1:0] retries_q;
    logic          no_contact_q;
    port_type_e    result_q;

    logic last_poll;
    assign last_poll = (polls_q == PW'(CONTACT_POLLS - 1));

    always_comb begin
        case (state_q)
            ST_CONTACT:   limit_o = TW'(CONTACT_POLL_MS);
            ST_PRIMARY:   limit_o = TW'(PRIMARY_MS);
            ST_SECONDARY: limit_o = TW'(SECONDARY_MS);
            default:      limit_o = TW'(1);
        endcase
    end

    assign run_o    = (state_q == ST_CONTACT) || (state_q == ST_PRIMARY) ||
                      (state_q == ST_SECONDARY);
    assign state_o  = state_q;
    assign done_o   = (state_q == ST_FINISH);
    assign result_o = result_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            polls_q      <= '0;
            retries_q    <= '0;
            no_contact_q <= 1'b0;
            result_q     <= PT_UNKNOWN;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q      <= ST_CONTACT;
                        polls_q      <= '0;
                        retries_q    <= '0;
                        no_contact_q <= 1'b0;
                        result_q     <= PT_UNKNOWN;
                    end
                end
                ST_CONTACT: begin
                    if (expire_i) begin
                        if (contact_i || last_poll) begin
                            state_q      <= ST_PRIMARY;
                            no_contact_q <= !contact_i;
                            retries_q    <= '0;
                        end else begin
                            polls_q <= polls_q + PW'(1);
                        end
                    end
                end
                ST_PRIMARY: begin
                    if (expire_i) begin
                        if (chgport_i) begin
                            state_q <= ST_SECONDARY;
                        end else if (no_contact_q) begin
                            state_q  <= ST_FINISH;
                            result_q <= PT_FLOATING;
                        end else if (retries_q == RW'(PRIMARY_RETRIES)) begin
                            state_q  <= ST_FINISH;
                            result_q <= PT_SDP;
                        end else begin
                            retries_q <= retries_q + RW'(1);
                        end
                    end
                end
                ST_SECONDARY: begin
                    if (expire_i) begin
                        state_q  <= ST_FINISH;
                        result_q <= dedport_i ? PT_DCP : PT_CDP;
                    end
                end
                ST_FINISH: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/chg_detect_seq.sv
module chg_detect_seq
    import chg_detect_pkg::*;
#(
    parameter int CONTACT_POLL_MS = 100,
    parameter int CONTACT_POLLS   = 6,
    parameter int PRIMARY_MS      = 40,
    parameter int SECONDARY_MS    = 40,
    parameter int PRIMARY_RETRIES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       ms_tick_i,
    input  logic       contact_i,
    input  logic       chgport_i,
    input  logic       dedport_i,
    output logic       en_dm_pulldown_o,
    output logic       en_dp_isrc_o,
    output logic       en_dp_vsrc_o,
    output logic       en_dm_vsrc_o,
    output logic       en_dp_isink_o,
    output logic       en_dm_isink_o,
    output logic       done_o,
    output logic [2:0] port_type_o
);
    localparam int LIM_MAX = max3(CONTACT_POLL_MS, PRIMARY_MS, SECONDARY_MS);
    localparam int TW      = $clog2(LIM_MAX + 1);

    logic          run;
    logic          expire;
    logic [TW-1:0] limit;
    seq_state_e    state;
    port_type_e    result;
    analog_en_t    en;

    chg_tick_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run_i    (run),
        .tick_i   (ms_tick_i),
        .limit_i  (limit),
        .expire_o (expire)
    );

    chg_seq_ctrl #(
        .CONTACT_POLL_MS (CONTACT_POLL_MS),
        .CONTACT_POLLS   (CONTACT_POLLS),
        .PRIMARY_MS      (PRIMARY_MS),
        .SECONDARY_MS    (SECONDARY_MS),
        .PRIMARY_RETRIES (PRIMARY_RETRIES),
        .TW              (TW)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .contact_i (contact_i),
        .chgport_i (chgport_i),
        .dedport_i (dedport_i),
        .expire_i  (expire),
        .run_o     (run),
        .limit_o   (limit),
        .state_o   (state),
        .done_o    (done_o),
        .result_o  (result)
    );

    chg_enable_decode u_dec (
        .state_i (state),
        .en_o    (en)
    );

    assign en_dm_pulldown_o = en.dm_pulldown;
    assign en_dp_isrc_o     = en.dp_isrc;
    assign en_dp_vsrc_o     = en.dp_vsrc;
    assign en_dm_vsrc_o     = en.dm_vsrc;
    assign en_dp_isink_o    = en.dp_isink;
    assign en_dm_isink_o    = en.dm_isink;
    assign port_type_o      = result;
endmodule

// File: rtl/chg_detect_seq_checker.sv
module chg_detect_seq_checker (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       en_dm_pulldown_o,
    input logic       en_dp_isrc_o,
    input logic       en_dp_vsrc_o,
    input logic       en_dm_vsrc_o,
    input logic       en_dp_isink_o,
    input logic       en_dm_isink_o,
    input logic       done_o,
    input logic [2:0] port_type_o
);
    logic [2:0] groups;
    logic       any_en;
    assign groups = {en_dm_pulldown_o, en_dp_vsrc_o, en_dm_vsrc_o};
    assign any_en = en_dm_pulldown_o | en_dp_isrc_o | en_dp_vsrc_o |
                    en_dm_vsrc_o | en_dp_isink_o | en_dm_isink_o;

    p_one_group_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(groups));

    p_contact_pair_r2: assert property (@(posedge clk) disable iff (rst)
        en_dm_pulldown_o == en_dp_isrc_o);

    p_primary_pair_r4: assert property (@(posedge clk) disable iff (rst)
        en_dp_vsrc_o == en_dm_isink_o);

    p_secondary_pair_r5: assert property (@(posedge clk) disable iff (rst)
        en_dm_vsrc_o == en_dp_isink_o);

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !any_en);

    p_done_known_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (port_type_o != 3'd0) && (port_type_o <= 3'd4));

    p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> ($stable(port_type_o) || done_o));

    p_contact_entry_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(en_dm_pulldown_o) |-> $past(start_i));
endmodule

bind chg_detect_seq chg_detect_seq_checker u_chk (
    .clk              (clk),
    .rst              (rst),
    .start_i          (start_i),
    .en_dm_pulldown_o (en_dm_pulldown_o),
    .en_dp_isrc_o     (en_dp_isrc_o),
    .en_dp_vsrc_o     (en_dp_vsrc_o),
    .en_dm_vsrc_o     (en_dm_vsrc_o),
    .en_dp_isink_o    (en_dp_isink_o),
    .en_dm_isink_o    (en_dm_isink_o),
    .done_o           (done_o),
    .port_type_o      (port_type_o)
);

// File: tb/chg_detect_seq_tb.sv
module chg_detect_seq_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic ms_tick_i = 1'b0;
    logic contact_i = 1'b0;
    logic chgport_i = 1'b0;
    logic dedport_i = 1'b0;
    logic en_dm_pulldown_o, en_dp_isrc_o, en_dp_vsrc_o, en_dm_vsrc_o;
    logic en_dp_isink_o, en_dm_isink_o, done_o;
    logic [2:0] port_type_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int divc = 0;

    always #5 clk = ~clk;

    chg_detect_seq u_dut (
        .clk (clk), .rst (rst), .start_i (start_i), .ms_tick_i (ms_tick_i),
        .contact_i (contact_i), .chgport_i (chgport_i), .dedport_i (dedport_i),
        .en_dm_pulldown_o (en_dm_pulldown_o), .en_dp_isrc_o (en_dp_isrc_o),
        .en_dp_vsrc_o (en_dp_vsrc_o), .en_dm_vsrc_o (en_dm_vsrc_o),
        .en_dp_isink_o (en_dp_isink_o), .en_dm_isink_o (en_dm_isink_o),
        .done_o (done_o), .port_type_o (port_type_o)
    );

    // Reference model: phase 0 idle, 1 contact, 2 primary, 3 secondary, 4 done
    int m_phase = 0, m_ticks = 0, m_polls = 0, m_tries = 0, m_res = 0;
    bit m_nocontact = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_ticks = 0; m_polls = 0; m_tries = 0; m_res = 0;
            m_nocontact = 0;
        end else begin
            case (m_phase)
                0: if (start_i) begin
                    m_phase = 1; m_ticks = 0; m_polls = 0; m_res = 0;
                end
                1: if (ms_tick_i) begin
                    m_ticks++;
                    if (m_ticks == 100) begin
                        m_ticks = 0; m_polls++;
                        if (contact_i || m_polls == 6) begin
                            m_nocontact = !contact_i; m_tries = 0; m_phase = 2;
                        end
                    end
                end
                2: if (ms_tick_i) begin
                    m_ticks++;
                    if (m_ticks == 40) begin
                        m_ticks = 0;
                        if (chgport_i) m_phase = 3;
                        else if (m_nocontact) begin m_res = 4; m_phase = 4; end
                        else if (m_tries == 2) begin m_res = 1; m_phase = 4; end
                        else m_tries++;
                    end
                end
                3: if (ms_tick_i) begin
                    m_ticks++;
                    if (m_ticks == 40) begin
                        m_ticks = 0; m_res = dedport_i ? 2 : 3; m_phase = 4;
                    end
                end
                default: m_phase = 0;
            endcase
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            automatic int exp_en = 0;
            automatic int act_en = {en_dm_pulldown_o, en_dp_isrc_o, en_dp_vsrc_o,
                                    en_dm_isink_o, en_dm_vsrc_o, en_dp_isink_o};
            automatic string tag;
            case (m_phase)
                1: begin exp_en = 6'b110000; tag = "R2 contact enables"; end
                2: begin exp_en = 6'b001100; tag = "R4 primary enables"; end
                3: begin exp_en = 6'b000011; tag = "R5 secondary enables"; end
                default: begin exp_en = 0; tag = "R8 quiet enables"; end
            endcase
            check(tag, act_en, exp_en);
            check("R8 done pulse", int'(done_o), (m_phase == 4) ? 1 : 0);
            check("R3 port type", int'(port_type_o), m_res);
        end
    end

    // millisecond tick: one cycle in four
    always @(negedge clk) begin
        divc = (divc + 1) % 4;
        ms_tick_i <= (divc == 0);
    end

    task automatic wait_ticks(input int n);
        repeat (n * 4) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_done();
        while (!done_o) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset type", int'(port_type_o), 0);
        check("R1 reset enables", int'({en_dm_pulldown_o, en_dp_isrc_o, en_dp_vsrc_o,
                                       en_dm_vsrc_o, en_dp_isink_o, en_dm_isink_o}), 0);
        check("R1 reset done", int'(done_o), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // S1: contact on second poll, charging + dedicated -> DCP
        contact_i = 0; chgport_i = 1; dedport_i = 1;
        pulse_start();
        wait_ticks(150); contact_i = 1;
        wait_done();
        check("R3 R5 DCP after late contact", int'(port_type_o), 2);
        repeat (5) @(negedge clk);
        check("R8 result held", int'(port_type_o), 2);

        // S2: contact at once, charging, no dedicated -> CDP; stray start mid-run
        contact_i = 1; chgport_i = 1; dedport_i = 0;
        pulse_start();
        @(negedge clk);
        check("R8 start clears result", int'(port_type_o), 0);
        wait_ticks(60);
        pulse_start();
        check("R9 start ignored keeps contact stage", int'(en_dm_pulldown_o), 1);
        wait_done();
        check("R5 CDP", int'(port_type_o), 3);
        pulse_start();   // lands on done or idle: done cycle start is ignored if in done
        wait_done();
        check("R5 CDP rerun", int'(port_type_o), 3);

        // S3: no contact, primary miss -> floating
        contact_i = 0; chgport_i = 0; dedport_i = 1;
        repeat (3) @(negedge clk);
        pulse_start();
        wait_done();
        check("R6 floating", int'(port_type_o), 4);

        // S4: contact, primary always misses -> SDP
        contact_i = 1; chgport_i = 0; dedport_i = 1;
        pulse_start();
        wait_done();
        check("R7 SDP after retries", int'(port_type_o), 1);

        // S5: contact, primary hits on a retry -> DCP
        contact_i = 1; chgport_i = 0; dedport_i = 1;
        pulse_start();
        wait_ticks(150); chgport_i = 1;
        wait_done();
        check("R7 retry hit DCP", int'(port_type_o), 2);

        // S6: no contact but primary hits -> secondary, CDP
        contact_i = 0; chgport_i = 1; dedport_i = 0;
        pulse_start();
        wait_done();
        check("R6 R3 timeout then hit CDP", int'(port_type_o), 3);
        repeat (4) @(negedge clk);
        check("R10 idle no enables", int'({en_dm_pulldown_o, en_dp_vsrc_o, en_dm_vsrc_o}), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule